// File: doc/BRIEF.md
# Low-Power Fixed-Priority Speed Controller

This block assists a fixed-priority preemptive real-time scheduler. At each scheduling point software raises a one-cycle evaluate strobe and presents the current time, the queue state and the timing figures of the active task. The block then picks a processor clock setting in 1 MHz steps and decides whether to request power-down. If a single task is ready and nothing waits in the run queue, the controller slows the clock so that the task's remaining worst-case cycles still finish by the earlier of its deadline and the next arrival from the delay queue. If every task is delayed, it requests power-down and loads a wake time early enough to cover the exit latency.

Time is an unsigned count in microseconds, so worst-case cycles divided by available microseconds gives MHz directly. A small sequential divider computes that ratio. A done strobe marks each new result. Queue maintenance and voltage control live outside the block.

Top module: `lpfs_speed_ctrl`

## Requirements
- R1: After reset the frequency output is 100, power-down is low, the wake time is 0 and done is low.
- R2: An evaluation with the all-delayed flag set takes priority over every other flag. One cycle later it pulses done, raises power-down, sets the frequency output to 8 and loads the wake time with the next arrival minus 10.
- R3: An evaluation without the all-delayed flag, where the run queue is non-empty or no task is active, gives a frequency of 100 with power-down low, with done one cycle later.
- R4: With the run queue empty and a task active, the frequency is the ceiling of remaining cycles over available time. Available time is the earlier of deadline and next arrival, minus the current time. Done is due 9 cycles after the evaluation.
- R5: A stretched result below 8 MHz, including zero remaining cycles, is raised to 8.
- R6: If the available time is zero (target not after now) or the remaining cycles exceed 100 times the available time, the result is 100 with done one cycle later.
- R7: An evaluation that arrives while a division is in progress is ignored. Exactly one done follows, carrying the first request's result.
- R8: The frequency output always lies between 8 and 100 inclusive.
- R9: When the next arrival is below 10, the loaded wake time saturates at 0.
- R10: Any evaluation that does not choose power-down drops the power-down request. The wake time then keeps its last loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | One-cycle strobe at a scheduling point |
| now_i | input | 32 | Current time in microseconds |
| runq_empty_i | input | 1 | High when no task waits in the run queue |
| task_active_i | input | 1 | High when a task holds the processor |
| rem_cycles_i | input | 32 | Remaining worst-case cycles of the active task |
| deadline_i | input | 32 | Absolute deadline of the active task |
| all_delayed_i | input | 1 | High when every task sits in the delay queue |
| next_arrival_i | input | 32 | Next arrival time of the delay-queue head |
| freq_mhz_o | output | 7 | Selected clock in MHz |
| power_down_o | output | 1 | Power-down request |
| wake_time_o | output | 32 | Time at which wake-up must start |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
Power-down and full-speed decisions are registered at the edge that samples the strobe, so their done appears one cycle after the evaluation. A stretched result needs one load edge, seven quotient edges and one write-back edge, so it is due nine cycles after the evaluation. The scoreboard records the cycle count at each evaluation together with the latency its case predicts. The monitor checks, on the falling edge where done is seen, both the values and that elapsed cycle count. Any done with no pending entry counts as a failure, which is how the ignored strobe of R7 is checked.

// File: rtl/lpfs_pkg.sv
// Shared types of the speed controller.
// Assumes nothing beyond the users importing it.
package lpfs_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } lpfs_state_t;

    typedef enum logic [1:0] {
        PATH_SLEEP,
        PATH_FULL,
        PATH_STRETCH
    } lpfs_path_t;
endpackage

// File: rtl/lpfs_window.sv
// Computes the time budget of the active task and whether it can be
// met at maximum speed, plus the wake time for a power-down.
// Assumes times do not wrap between now and the target.
module lpfs_window #(
    parameter int TW        = 32,
    parameter int FW        = 7,
    parameter int F_MAX     = 100,
    parameter int WAKE_LEAD = 10
) (
    input  logic [TW-1:0] now,
    input  logic [TW-1:0] deadline,
    input  logic [TW-1:0] next_arr,
    input  logic [TW-1:0] rem,
    output logic [TW-1:0] avail,
    output logic          feasible,
    output logic [TW-1:0] wake
);
    localparam int XW = TW + FW;

    logic [TW-1:0] target;
    logic [XW-1:0] cap;
    logic [XW-1:0] rem_ext;

    // Earlier of deadline and next arrival, and time left until it.
    always_comb begin
        target = (deadline < next_arr) ? deadline : next_arr;
        avail  = (target > now) ? (target - now) : '0;
    end

    // Cycles available at full speed versus cycles required.
    always_comb begin
        cap      = {{FW{1'b0}}, avail} * XW'(F_MAX);
        rem_ext  = {{FW{1'b0}}, rem};
        feasible = (avail != '0) && (rem_ext <= cap);
    end

    // Wake-up start, saturated at zero.
    always_comb begin
        wake = (next_arr >= TW'(WAKE_LEAD)) ? (next_arr - TW'(WAKE_LEAD)) : '0;
    end
endmodule

// File: rtl/lpfs_path_sel.sv
// Chooses the decision path from the queue flags.
// Power-down wins, then stretching for a lone feasible task, else full speed.
module lpfs_path_sel
    import lpfs_pkg::*;
(
    input  logic       all_delayed,
    input  logic       runq_empty,
    input  logic       task_active,
    input  logic       feasible,
    output lpfs_path_t path
);
    // Priority decode of the three paths.
    always_comb begin
        if (all_delayed)
            path = PATH_SLEEP;
        else if (runq_empty && task_active && feasible)
            path = PATH_STRETCH;
        else
            path = PATH_FULL;
    end
endmodule

// File: rtl/lpfs_ceil_div.sv
// Restoring divider giving ceil(num/den) in QW quotient bits, one bit
// per cycle. Assumes the caller guarantees num <= (2**QW - 1) * den.
module lpfs_ceil_div #(
    parameter int TW = 32,
    parameter int QW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] num,
    input  logic [TW-1:0] den,
    output logic          valid,
    output logic [QW-1:0] quot
);
    localparam int PW = TW + QW;
    localparam int CW = $clog2(QW + 1);

    logic [PW-1:0] part_q;
    logic [PW-1:0] dsh_q;
    logic [QW-1:0] q_q;
    logic [CW-1:0] step_q;
    logic          busy_q;

    // Load operands, then resolve one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            dsh_q  <= '0;
            q_q    <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                part_q <= PW'(num);
                dsh_q  <= PW'(den) << (QW - 1);
                q_q    <= '0;
                step_q <= CW'(QW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (part_q >= dsh_q) begin
                    part_q <= part_q - dsh_q;
                    q_q    <= {q_q[QW-2:0], 1'b1};
                end else begin
                    q_q    <= {q_q[QW-2:0], 1'b0};
                end
                dsh_q  <= dsh_q >> 1;
                step_q <= step_q - CW'(1);
                if (step_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    valid  <= 1'b1;
                end
            end
        end
    end

    // Round up when a remainder is left.
    assign quot = q_q + QW'(part_q != '0);
endmodule

// File: rtl/lpfs_speed_ctrl.sv
// Top of the speed controller. On an evaluate strobe in idle it either
// requests power-down, forces full speed, or starts a division that
// stretches the lone active task to its time budget.
// Assumes eval_i is a single-cycle strobe; strobes while dividing are dropped.
module lpfs_speed_ctrl
    import lpfs_pkg::*;
#(
    parameter int TW        = 32,
    parameter int F_MIN     = 8,
    parameter int F_MAX     = 100,
    parameter int WAKE_LEAD = 10,
    localparam int FW       = $clog2(F_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_i,
    input  logic [TW-1:0] now_i,
    input  logic          runq_empty_i,
    input  logic          task_active_i,
    input  logic [TW-1:0] rem_cycles_i,
    input  logic [TW-1:0] deadline_i,
    input  logic          all_delayed_i,
    input  logic [TW-1:0] next_arrival_i,
    output logic [FW-1:0] freq_mhz_o,
    output logic          power_down_o,
    output logic [TW-1:0] wake_time_o,
    output logic          done_o
);
    lpfs_state_t   state_q;
    lpfs_path_t    path;
    logic [TW-1:0] avail;
    logic          feasible;
    logic [TW-1:0] wake_c;
    logic          div_start;
    logic          div_valid;
    logic [FW-1:0] div_quot;
    logic [FW-1:0] div_clamped;
    logic          idle_w;

    lpfs_window #(
        .TW(TW), .FW(FW), .F_MAX(F_MAX), .WAKE_LEAD(WAKE_LEAD)
    ) u_window (
        .now      (now_i),
        .deadline (deadline_i),
        .next_arr (next_arrival_i),
        .rem      (rem_cycles_i),
        .avail    (avail),
        .feasible (feasible),
        .wake     (wake_c)
    );

    lpfs_path_sel u_path (
        .all_delayed (all_delayed_i),
        .runq_empty  (runq_empty_i),
        .task_active (task_active_i),
        .feasible    (feasible),
        .path        (path)
    );

    lpfs_ceil_div #(
        .TW(TW), .QW(FW)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (rem_cycles_i),
        .den   (avail),
        .valid (div_valid),
        .quot  (div_quot)
    );

    assign idle_w    = (state_q == ST_IDLE);
    assign div_start = idle_w && eval_i && (path == PATH_STRETCH);

    // Raise a stretched result to the lowest selectable step.
    assign div_clamped = (div_quot < FW'(F_MIN)) ? FW'(F_MIN) : div_quot;

    // Decision sequencer and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            freq_mhz_o   <= FW'(F_MAX);
            power_down_o <= 1'b0;
            wake_time_o  <= '0;
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (eval_i) begin
                        case (path)
                            PATH_SLEEP: begin
                                power_down_o <= 1'b1;
                                freq_mhz_o   <= FW'(F_MIN);
                                wake_time_o  <= wake_c;
                                done_o       <= 1'b1;
                            end
                            PATH_STRETCH: begin
                                power_down_o <= 1'b0;
                                state_q      <= ST_WAIT;
                            end
                            default: begin
                                power_down_o <= 1'b0;
                                freq_mhz_o   <= FW'(F_MAX);
                                done_o       <= 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    if (div_valid) begin
                        freq_mhz_o <= div_clamped;
                        done_o     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lpfs_speed_ctrl_chk.sv
// Property checker for the speed controller, bound to its top.
// Assumes it observes the top's ports and its idle indication.
module lpfs_speed_ctrl_chk #(
    parameter int TW        = 32,
    parameter int FW        = 7,
    parameter int F_MIN     = 8,
    parameter int F_MAX     = 100,
    parameter int WAKE_LEAD = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idle,
    input logic          eval,
    input logic          runq_empty,
    input logic          task_active,
    input logic          all_delayed,
    input logic [TW-1:0] next_arrival,
    input logic [FW-1:0] freq,
    input logic          pd,
    input logic [TW-1:0] wake,
    input logic          done
);
    assert_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && idle && all_delayed) |=> (done && pd && freq == FW'(F_MIN)));

    assert_wake_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && idle && all_delayed && next_arrival < TW'(WAKE_LEAD)) |=> (wake == '0));

    assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && idle && !all_delayed && (!runq_empty || !task_active))
        |=> (done && !pd && freq == FW'(F_MAX)));

    assert_freq_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (freq >= FW'(F_MIN)) && (freq <= FW'(F_MAX)));

    assert_no_pd_while_dividing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !pd);
endmodule

bind lpfs_speed_ctrl lpfs_speed_ctrl_chk #(
    .TW(TW), .FW(FW), .F_MIN(F_MIN), .F_MAX(F_MAX), .WAKE_LEAD(WAKE_LEAD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle         (idle_w),
    .eval         (eval_i),
    .runq_empty   (runq_empty_i),
    .task_active  (task_active_i),
    .all_delayed  (all_delayed_i),
    .next_arrival (next_arrival_i),
    .freq         (freq_mhz_o),
    .pd           (power_down_o),
    .wake         (wake_time_o),
    .done         (done_o)
);

// File: tb/test_lpfs_speed_ctrl.sv
`timescale 1ns/1ps
module test_lpfs_speed_ctrl;
    localparam int TW = 32;
    localparam int FW = 7;

    typedef struct {
        string       tag;
        logic [6:0]  freq;
        logic        pd;
        logic [31:0] wake;
        int          lat;
        int          issue;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eval_i = 1'b0;
    logic [31:0]   now_i = '0;
    logic          runq_empty_i = 1'b1;
    logic          task_active_i = 1'b0;
    logic [31:0]   rem_cycles_i = '0;
    logic [31:0]   deadline_i = '0;
    logic          all_delayed_i = 1'b0;
    logic [31:0]   next_arrival_i = '0;
    logic [6:0]    freq_mhz_o;
    logic          power_down_o;
    logic [31:0]   wake_time_o;
    logic          done_o;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 0;
    exp_t sb[$];
    logic [31:0] last_wake = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpfs_speed_ctrl i_lpfs_speed_ctrl (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .now_i(now_i),
        .runq_empty_i(runq_empty_i), .task_active_i(task_active_i),
        .rem_cycles_i(rem_cycles_i), .deadline_i(deadline_i),
        .all_delayed_i(all_delayed_i), .next_arrival_i(next_arrival_i),
        .freq_mhz_o(freq_mhz_o), .power_down_o(power_down_o),
        .wake_time_o(wake_time_o), .done_o(done_o)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops an expected item at each done and compares it.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R7 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "freq", freq_mhz_o, e.freq);
                check(e.tag, "power_down", power_down_o, e.pd);
                check(e.tag, "wake", wake_time_o, e.wake);
                check(e.tag, "latency", cyc - e.issue, e.lat);
                check("R8", "freq in range", (freq_mhz_o >= 8 && freq_mhz_o <= 100), 1);
            end
        end
    end

    // Driver: applies one evaluation and queues what it must produce.
    task automatic fire(input string tag, input logic [31:0] now, input logic rq_empty,
                        input logic active, input logic [31:0] rem, input logic [31:0] dl,
                        input logic all_del, input logic [31:0] na);
        exp_t        e;
        longint      target, avail, q;
        @(negedge clk);
        now_i = now; runq_empty_i = rq_empty; task_active_i = active;
        rem_cycles_i = rem; deadline_i = dl; all_delayed_i = all_del; next_arrival_i = na;
        eval_i = 1'b1;
        e.tag = tag; e.issue = cyc; e.lat = 1; e.pd = 1'b0; e.wake = last_wake;
        target = (dl < na) ? dl : na;
        avail  = (target > now) ? target - now : 0;
        if (all_del) begin
            e.pd = 1'b1; e.freq = 7'd8;
            e.wake = (na >= 10) ? na - 10 : 0;
            last_wake = e.wake;
        end else if (!rq_empty || !active || avail == 0 || longint'(rem) > 100 * avail) begin
            e.freq = 7'd100;
        end else begin
            q = (longint'(rem) + avail - 1) / avail;
            if (q < 8) q = 8;
            e.freq = 7'(q);
            e.lat = 9;
        end
        sb.push_back(e);
        @(negedge clk);
        eval_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset freq", freq_mhz_o, 100);
        check("R1", "reset power_down", power_down_o, 0);
        check("R1", "reset wake", wake_time_o, 0);
        check("R1", "reset done", done_o, 0);

        fire("R2", 100, 1, 0, 0, 0, 1, 500);          // sleep, wake 490
        fire("R10", 200, 0, 1, 10, 900, 0, 900);      // full speed, pd dropped, wake kept
        fire("R4", 1000, 1, 1, 5000, 1100, 0, 1200);  // 50
        fire("R4", 0, 1, 1, 3000, 300, 0, 70);        // arrival earlier: 43
        fire("R4", 0, 1, 1, 7000, 70, 0, 900);        // exactly 100 via divider
        fire("R4", 0, 1, 1, 801, 100, 0, 900);        // 9
        fire("R6", 0, 1, 1, 7001, 70, 0, 900);        // infeasible
        fire("R6", 500, 1, 1, 10, 400, 0, 900);       // deadline passed
        fire("R5", 0, 1, 1, 100, 100, 0, 900);        // 1 -> 8
        fire("R5", 0, 1, 1, 0, 100, 0, 900);          // 0 -> 8
        fire("R9", 0, 0, 1, 50, 100, 1, 5);           // sleep wins, wake 0
        fire("R3", 0, 1, 0, 50, 100, 0, 900);         // no active task

        // R7: strobe while dividing is dropped.
        begin
            exp_t e;
            @(negedge clk);
            now_i = 1000; runq_empty_i = 1; task_active_i = 1; rem_cycles_i = 5000;
            deadline_i = 1100; all_delayed_i = 0; next_arrival_i = 1200; eval_i = 1'b1;
            e.tag = "R7"; e.issue = cyc; e.lat = 9; e.pd = 0; e.wake = last_wake; e.freq = 7'd50;
            sb.push_back(e);
            @(negedge clk); eval_i = 1'b0;
            @(negedge clk); runq_empty_i = 0; eval_i = 1'b1;
            @(negedge clk); eval_i = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (12) @(negedge clk);
            check("R7", "freq after dropped strobe", freq_mhz_o, 50);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule